// File: doc/BRIEF.md
# Host DRAM Write Mirror

This block sits beside a host system's dynamic RAM and only observes its bus. The address arrives in two halves on shared lines: the row half while the row strobe falls, then the column half while the column strobe falls. Two top lines of each half come in on separate pins. The block rebuilds the full address from both halves. When the column strobe falls during a processor write, the block copies the data byte into an internal dual-port mirror RAM.

The video engine reads the mirror through a second, independent port at the full FPGA rate. It never waits on the host bus phase. A host reset output is held active until the FPGA logic reports that it is ready, then for a further programmable number of cycles. With `ADDR_W` set to 16 the mirror spans 64 KB. The default is smaller so that it elaborates quickly.

Top module: `dram_mirror`

## Requirements
- R1: `host_rst_no` is low while `rst_ni` is low or `ready_i` is low. After `ready_i` is sampled high on `HOLD_CYC` consecutive rising edges of `clk_i`, `host_rst_no` goes high. A low `ready_i` drives it low again one cycle later and restarts the count.
- R2: The row half is taken from the address lines when the synchronized row strobe falls. The column half is taken when the synchronized column strobe falls. Each half is `{ma_hi_i, ma_i}`, with the separate lines as its top bits. The rebuilt address is `{row half, column half}`.
- R3: A mirror write stores `wdata_i` at the rebuilt address. It happens when a column strobe fall is detected while `we_ni` is 0 and `char_rom_ni` is 1.
- R4: While `char_rom_ni` is 0 at the column strobe fall, the mirror is not written.
- R5: While `we_ni` is 1 at the column strobe fall (a host read), the mirror is not written.
- R6: A column strobe held low produces exactly one write. The data captured is the data present when the fall is detected, and later changes on `wdata_i` are ignored.
- R7: `rd_data_o` shows the mirror content at `rd_addr_i` one `rd_clk_i` rising edge after the address is applied.
- R8: Both strobes pass through two flip-flops, so the write lands on the third `clk_i` rising edge after the column strobe falls. A read of the same address on that edge returns the old byte. The next read returns the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | FPGA snoop clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ready_i | input | 1 | FPGA logic ready |
| host_rst_no | output | 1 | Active-low reset to host processor |
| ras_ni | input | 1 | Host row strobe, active low |
| cas_ni | input | 1 | Host column strobe, active low |
| we_ni | input | 1 | Host write enable, active low |
| char_rom_ni | input | 1 | Character ROM select, active low |
| ma_i | input | ADDR_W/2-HI_W | Multiplexed address lines on normal pins |
| ma_hi_i | input | HI_W | Two top multiplexed address lines, separate pins |
| wdata_i | input | DATA_W | Host data bus |
| rd_clk_i | input | 1 | Video read clock |
| rd_addr_i | input | ADDR_W | Video read address |
| rd_data_o | output | DATA_W | Video read data |

## Verification
A mirror write and a video read of the same address can fall on the same rising edge. The bench runs both ports from one clock to provoke this. It holds the read address on the target, starts a column strobe fall, and counts three edges. It then expects the old byte on the first read and the new byte on the next. A sweep of every address first seeds known contents. Overwrites attempted under the character-ROM select, with write enable high, or with a held strobe are then judged against a model of the mirror kept in the bench.

// File: rtl/mirror_pkg.sv
package mirror_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  function automatic int unsigned half_w(input int unsigned aw);
    return aw / 2;
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic fall_o
);
  import mirror_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_ni};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];

  // R6
  single_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/addr_rebuild.sv
module addr_rebuild #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned HI_W   = 2,
  localparam int unsigned HALF_W = ADDR_W / 2,
  localparam int unsigned LO_W   = HALF_W - HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              row_fall_i,
  input  logic [LO_W-1:0]   ma_i,
  input  logic [HI_W-1:0]   ma_hi_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [HALF_W-1:0] row_q;
  logic [HALF_W-1:0] lines;

  assign lines = {ma_hi_i, ma_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         row_q <= '0;
    else if (row_fall_i) row_q <= lines;
  end

  // column half is used live in the cycle its strobe fall is seen
  assign addr_o = {row_q, lines};
endmodule

// File: rtl/mirror_ram.sv
module mirror_ram #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              wr_clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_clk_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge rd_clk_i) begin
    rd_data_o <= mem[rd_addr_i];
  end
endmodule

// File: rtl/host_rst_hold.sv
module host_rst_hold #(
  parameter int unsigned HOLD_CYC = 1024,
  localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  output logic host_rst_no
);
  localparam logic [CNT_W-1:0] HOLD = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!ready_i)      cnt_q <= '0;
    else if (cnt_q != HOLD) cnt_q <= cnt_q + 1'b1;
  end

  assign host_rst_no = (cnt_q == HOLD);

  // R1
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= HOLD);
  // R1
  drop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> !host_rst_no);
  // R1
  release_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_rst_no) |-> $past(ready_i));
endmodule

// File: rtl/dram_mirror.sv
module dram_mirror #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned HI_W     = 2,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned HOLD_CYC = 1024,
  localparam int unsigned HALF_W  = ADDR_W / 2,
  localparam int unsigned LO_W    = HALF_W - HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ready_i,
  output logic              host_rst_no,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              char_rom_ni,
  input  logic [LO_W-1:0]   ma_i,
  input  logic [HI_W-1:0]   ma_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_clk_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              row_fall, col_fall, wr_fire;
  logic [ADDR_W-1:0] wr_addr;

  strobe_sync u_ras_sync (.clk_i, .rst_ni, .strobe_ni(ras_ni), .fall_o(row_fall));
  strobe_sync u_cas_sync (.clk_i, .rst_ni, .strobe_ni(cas_ni), .fall_o(col_fall));

  addr_rebuild #(.ADDR_W(ADDR_W), .HI_W(HI_W)) u_addr (
    .clk_i, .rst_ni, .row_fall_i(row_fall), .ma_i, .ma_hi_i, .addr_o(wr_addr)
  );

  // host write to DRAM only; character ROM cycles are not DRAM traffic
  assign wr_fire = col_fall & ~we_ni & char_rom_ni;

  mirror_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .wr_clk_i(clk_i), .wr_en_i(wr_fire), .wr_addr_i(wr_addr), .wr_data_i(wdata_i),
    .rd_clk_i, .rd_addr_i, .rd_data_o
  );

  host_rst_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk_i, .rst_ni, .ready_i, .host_rst_no
  );

  // R3
  fire_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |-> ($past(cas_ni, 2) == 1'b0));
  // R6
  one_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |=> !wr_fire);
endmodule

// File: tb/dram_mirror_tb_top.sv
module dram_mirror_tb_top;
  localparam int AW = 8, HW = 2, DW = 8, HOLD = 16;
  localparam int LW = AW / 2 - HW;

  logic clk = 1'b0, rst_ni = 1'b0, ready = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, crom_n = 1'b1;
  logic [LW-1:0] ma = '0;
  logic [HW-1:0] ma_hi = '0;
  logic [DW-1:0] wdata = '0;
  logic [AW-1:0] raddr = '0;
  logic [DW-1:0] rdata;
  logic host_rst_n;

  int total = 0, bad = 0;
  logic [DW-1:0] model [1 << AW];

  always #10 clk = ~clk;

  dram_mirror #(.ADDR_W(AW), .HI_W(HW), .DATA_W(DW), .HOLD_CYC(HOLD)) dut_i (
    .clk_i(clk), .rst_ni, .ready_i(ready), .host_rst_no(host_rst_n),
    .ras_ni(ras_n), .cas_ni(cas_n), .we_ni(we_n), .char_rom_ni(crom_n),
    .ma_i(ma), .ma_hi_i(ma_hi), .wdata_i(wdata),
    .rd_clk_i(clk), .rd_addr_i(raddr), .rd_data_o(rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic put_half(input logic [AW/2-1:0] h);
    {ma_hi, ma} = h;
  endtask

  // full host cycle; strobes held 4 clocks each
  task automatic host_cyc(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic wn, input logic cn);
    @(negedge clk); put_half(a[AW-1:AW/2]); ras_n = 1'b0;
    repeat (4) @(negedge clk);
    put_half(a[AW/2-1:0]); we_n = wn; crom_n = cn; wdata = d; cas_n = 1'b0;
    repeat (4) @(negedge clk);
    cas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1; crom_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string req);
    @(negedge clk); raddr = a;
    @(negedge clk);
    chk(rdata == model[a], req, rdata, model[a]);
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 37 + 11 + k * 101) & 8'hff);
  endfunction

  initial begin
    #3_000_000;
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(host_rst_n == 1'b0, "R1 in reset", host_rst_n, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(host_rst_n == 1'b0, "R1 not ready", host_rst_n, 0);
    ready = 1'b1;
    repeat (HOLD - 1) @(negedge clk);
    chk(host_rst_n == 1'b0, "R1 one before release", host_rst_n, 0);
    @(negedge clk);
    chk(host_rst_n == 1'b1, "R1 released", host_rst_n, 1);
    ready = 1'b0;
    @(negedge clk);
    chk(host_rst_n == 1'b0, "R1 ready drop", host_rst_n, 0);
    ready = 1'b1;
    repeat (HOLD - 1) @(negedge clk);
    chk(host_rst_n == 1'b0, "R1 restart count", host_rst_n, 0);
    @(negedge clk);
    chk(host_rst_n == 1'b1, "R1 released again", host_rst_n, 1);

    // R2 R3: write every address, read back
    for (int a = 0; a < (1 << AW); a++) begin
      host_cyc(AW'(a), pat(a, 0), 1'b0, 1'b1);
      model[a] = pat(a, 0);
    end
    for (int a = 0; a < (1 << AW); a++) rd_chk(AW'(a), "R2 R3 R7 sweep");

    // R4: character ROM select blocks writes
    for (int a = 0; a < (1 << AW); a += 17) begin
      host_cyc(AW'(a), pat(a, 1), 1'b0, 1'b0);
      rd_chk(AW'(a), "R4 char rom");
    end
    // R5: host read cycles leave mirror unchanged
    for (int a = 3; a < (1 << AW); a += 19) begin
      host_cyc(AW'(a), pat(a, 2), 1'b1, 1'b1);
      rd_chk(AW'(a), "R5 host read");
    end

    // R6: strobe held low, data changes afterwards
    @(negedge clk); put_half(8'h5a >> 4); ras_n = 1'b0;
    repeat (4) @(negedge clk);
    put_half(4'ha); we_n = 1'b0; wdata = 8'hc3; cas_n = 1'b0;
    repeat (6) @(negedge clk);
    wdata = 8'h3c;
    repeat (14) @(negedge clk);
    cas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1;
    model[8'h5a] = 8'hc3;
    rd_chk(8'h5a, "R6 held strobe");

    // R8: collision on the write edge returns old then new
    raddr = 8'hb7;
    put_half(4'hb); ras_n = 1'b0;
    repeat (4) @(negedge clk);
    put_half(4'h7); we_n = 1'b0; wdata = 8'h99; cas_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rdata == model[8'hb7], "R8 old on collision", rdata, model[8'hb7]);
    @(negedge clk);
    chk(rdata == 8'h99, "R8 new after collision", rdata, 8'h99);
    cas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1;
    model[8'hb7] = 8'h99;
    repeat (2) @(negedge clk);

    // R2: neighbours differing only in separate lines stay intact
    rd_chk(8'h77, "R2 high lines row");
    rd_chk(8'hbb, "R2 high lines col");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule